// File: doc/BRIEF.md
# Reverse-Map Entry Locator

This block turns a system physical address into the address of the 16-byte reverse-map record that guards the 4KB page holding that address. It supports two table layouts, picked by bit 0 of a configuration word. In the flat layout, records sit directly after a 16KB housekeeping area that starts at the table base, one record per page. In the segmented layout, physical memory is cut into equal power-of-two segments. A 4KB directory of 8-byte segment descriptors sits after the housekeeping area. The block fetches the one descriptor it needs over a single-read memory port before it forms the record address.

A requester offers an address with a valid/ready handshake and receives one response strobe. The strobe carries either the record address or a 2-bit fault code. The base, last-byte and configuration values are static inputs. They are assumed stable while a lookup is in flight.

Top module: `rmp_locator`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_rd_valid` are 0.
- R2: Flat layout (`cfg_ctrl[0]`=0): an accepted address PA gives, in the cycle right after acceptance, `rsp_valid`=1, `rsp_fault`=0 and `rsp_addr` = BASE + 0x4000 + (PA>>12)*16.
- R3: Flat layout: when PA >= ((LAST+1-BASE-0x4000)/16)*4096, the response faults with code 0 (out of range) and no memory read is issued.
- R4: When BASE or LAST+1 is not a multiple of 8KB, or LAST+1 < BASE+0x4000 (plus 0x1000 more in segmented layout), every lookup faults with code 3 one cycle after acceptance, with no memory read.
- R5: Segmented layout (`cfg_ctrl[0]`=1, segment exponent S=`cfg_ctrl[13:8]`): exactly one one-cycle read is issued, in the cycle after acceptance, at BASE + 0x4000 + 8*(PA>>S).
- R6: Segmented layout: the descriptor limit is 512, or `cfg_seg_cap` when `cfg_cap_hard`=1 and that is smaller. An index PA>>S at or above the limit faults with code 0 one cycle after acceptance, with no read.
- R7: A fetched descriptor whose bits 19:0 (mapped size in GB) are zero faults with code 1.
- R8: When the in-segment offset PA mod 2^S is >= mapped size * 2^30, the lookup faults with code 2.
- R9: Otherwise `rsp_addr` = (descriptor bits 51:20)<<20 + (offset>>12)*16. The response comes in the cycle after the read data is taken.
- R10: `req_ready` is 0 from acceptance until the response cycle ends. Requests offered then and read data arriving outside the wait for a descriptor have no effect.
- R11: `rsp_valid` is a one-cycle strobe followed by `req_ready`=1. On a fault, `rsp_fault`=1 and `rsp_addr`=0. On success, `rsp_fault`=0 and `rsp_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | 52 | Table base address (start of housekeeping area) |
| cfg_last | input | 52 | Address of the table's last byte |
| cfg_ctrl | input | 14 | Bit 0 selects segmented layout; bits 13:8 hold log2 of the segment size |
| cfg_seg_cap | input | 10 | Usable descriptor count when the cap is hard |
| cfg_cap_hard | input | 1 | Enforce `cfg_seg_cap` as the descriptor limit |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_pa | input | 52 | Physical address to locate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 2 | Fault code: 0 range, 1 empty segment, 2 beyond mapped size, 3 configuration |
| rsp_addr | output | 52 | Record address on success |
| mem_rd_valid | output | 1 | Descriptor read request, one cycle |
| mem_rd_addr | output | 52 | Descriptor address |
| mem_rd_data_valid | input | 1 | Read data present |
| mem_rd_data | input | 64 | Descriptor contents |

## Verification
The flat layout is tried at page 0, at the last covered page and one page past it. This separates an off-by-one in the limit from a wrong record stride. Alignment faults are raised separately on the base, on the end and on an area too small to hold its housekeeping. The segmented layout is tried with 1GB and 64GB segments and several indices, which exposes a wrong shift amount in the descriptor address. It is also tried with descriptors that are empty, that end just short of the offset and that end just past it, which separates the three fault paths. The hard and soft descriptor caps at the same index show whether the cap flag is honoured. Stray requests and read data arriving while the block is busy or idle check that only the waiting state consumes them.

// File: rtl/rmp_pkg.sv
package rmp_pkg;
    localparam int unsigned BOOK_BYTES = 16384;
    localparam int unsigned DIR_BYTES  = 4096;
    localparam int unsigned DIR_MAX    = 512;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_WAIT, ST_DONE, ST_FAULT
    } lkp_state_e;

    typedef enum logic [1:0] {
        FLT_RANGE = 2'd0,
        FLT_EMPTY = 2'd1,
        FLT_SHORT = 2'd2,
        FLT_CFG   = 2'd3
    } flt_code_e;
endpackage

// File: rtl/rmp_cfg_check.sv
module rmp_cfg_check #(
    parameter int PA_W     = 52,
    parameter int ALIGN_LG = 13
) (
    input  logic [PA_W-1:0] base,
    input  logic [PA_W-1:0] last,
    input  logic            seg_mode,
    output logic            cfg_err,
    output logic [PA_W+8:0] flat_limit
);
    import rmp_pkg::*;
    localparam logic [PA_W:0] BOOK = (PA_W+1)'(BOOK_BYTES);
    localparam logic [PA_W:0] DIR  = (PA_W+1)'(DIR_BYTES);

    logic [PA_W:0] top_x, need, span;
    logic          misaligned, too_small;

    always_comb begin
        top_x      = {1'b0, last} + (PA_W+1)'(1);
        need       = {1'b0, base} + BOOK + (seg_mode ? DIR : '0);
        misaligned = (|base[ALIGN_LG-1:0]) | (|top_x[ALIGN_LG-1:0]);
        too_small  = top_x < need;
        cfg_err    = misaligned | too_small;
        span       = top_x - ({1'b0, base} + BOOK);
        flat_limit = {span, 8'b0};
    end
endmodule

// File: rtl/rmp_seg_index.sv
module rmp_seg_index #(
    parameter int PA_W  = 52,
    parameter int CNT_W = 10,
    parameter int IDX_W = 9
) (
    input  logic [PA_W-1:0]  pa,
    input  logic [5:0]       seg_lg,
    input  logic [CNT_W-1:0] cap,
    input  logic             cap_hard,
    output logic             idx_ok,
    output logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  offset
);
    import rmp_pkg::*;
    localparam logic [CNT_W:0] DMAX = (CNT_W+1)'(DIR_MAX);

    logic [PA_W-1:0]  idx_full;
    logic [CNT_W:0]   limit;

    always_comb begin
        idx_full = pa >> seg_lg;
        limit    = (cap_hard && ({1'b0, cap} < DMAX)) ? {1'b0, cap} : DMAX;
        idx_ok   = idx_full < PA_W'(limit);
        idx      = idx_full[IDX_W-1:0];
        offset   = pa & ~({PA_W{1'b1}} << seg_lg);
    end
endmodule

// File: rtl/rmp_entry_form.sv
module rmp_entry_form #(
    parameter int PA_W = 52
) (
    input  logic [51:0]     desc,
    input  logic [PA_W-1:0] offset,
    output logic            empty,
    output logic            beyond,
    output logic [PA_W-1:0] entry
);
    logic [63:0] off_w, mapped_w;

    always_comb begin
        off_w    = 64'(offset);
        mapped_w = {14'b0, desc[19:0], 30'b0};
        empty    = desc[19:0] == 20'd0;
        beyond   = off_w >= mapped_w;
        entry    = PA_W'({desc[51:20], 20'b0}) + PA_W'({offset[PA_W-1:12], 4'b0000});
    end
endmodule

// File: rtl/rmp_locator.sv
module rmp_locator #(
    parameter int PA_W  = 52,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [PA_W-1:0]  cfg_last,
    input  logic [13:0]      cfg_ctrl,
    input  logic [CNT_W-1:0] cfg_seg_cap,
    input  logic             cfg_cap_hard,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PA_W-1:0]  req_pa,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [1:0]       rsp_code,
    output logic [PA_W-1:0]  rsp_addr,
    output logic             mem_rd_valid,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_data_valid,
    input  logic [63:0]      mem_rd_data
);
    import rmp_pkg::*;
    localparam int IDX_W = $clog2(DIR_MAX);
    localparam logic [PA_W-1:0] BOOK = PA_W'(BOOK_BYTES);

    typedef struct packed {
        lkp_state_e      st;
        logic [PA_W-1:0] pa;
        logic [PA_W-1:0] addr;
        flt_code_e       code;
    } lkp_t;

    lkp_t d, q;

    logic            seg_mode;
    logic [5:0]      seg_lg;
    logic            cfg_err;
    logic [PA_W+8:0] flat_limit;
    logic [PA_W-1:0] cur_pa, offset, seg_entry, flat_entry;
    logic            idx_ok, empty, beyond;
    logic [IDX_W-1:0] idx;
    logic [18:0]     unused_bits;

    assign seg_mode    = cfg_ctrl[0];
    assign seg_lg      = cfg_ctrl[13:8];
    assign unused_bits = {cfg_ctrl[7:1], mem_rd_data[63:52]};
    assign cur_pa      = (q.st == ST_IDLE) ? req_pa : q.pa;
    assign flat_entry  = cfg_base + BOOK + PA_W'({req_pa[PA_W-1:12], 4'b0000});

    rmp_cfg_check #(.PA_W(PA_W)) u_cfg (
        .base(cfg_base), .last(cfg_last), .seg_mode(seg_mode),
        .cfg_err(cfg_err), .flat_limit(flat_limit)
    );

    rmp_seg_index #(.PA_W(PA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_idx (
        .pa(cur_pa), .seg_lg(seg_lg), .cap(cfg_seg_cap), .cap_hard(cfg_cap_hard),
        .idx_ok(idx_ok), .idx(idx), .offset(offset)
    );

    rmp_entry_form #(.PA_W(PA_W)) u_ent (
        .desc(mem_rd_data[51:0]), .offset(offset),
        .empty(empty), .beyond(beyond), .entry(seg_entry)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.pa   = req_pa;
                    d.addr = '0;
                    d.code = FLT_RANGE;
                    if (cfg_err) begin
                        d.st   = ST_FAULT;
                        d.code = FLT_CFG;
                    end else if (!seg_mode) begin
                        if ({9'b0, req_pa} >= flat_limit) begin
                            d.st = ST_FAULT;
                        end else begin
                            d.st   = ST_DONE;
                            d.addr = flat_entry;
                        end
                    end else if (!idx_ok) begin
                        d.st = ST_FAULT;
                    end else begin
                        d.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rd_data_valid) begin
                    if (empty) begin
                        d.st   = ST_FAULT;
                        d.code = FLT_EMPTY;
                    end else if (beyond) begin
                        d.st   = ST_FAULT;
                        d.code = FLT_SHORT;
                    end else begin
                        d.st   = ST_DONE;
                        d.addr = seg_entry;
                    end
                end
            end
            default: begin
                d.st   = ST_IDLE;
                d.addr = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.pa   <= '0;
            q.addr <= '0;
            q.code <= FLT_RANGE;
        end else begin
            q <= d;
        end
    end

    assign req_ready    = q.st == ST_IDLE;
    assign rsp_valid    = (q.st == ST_DONE) || (q.st == ST_FAULT);
    assign rsp_fault    = q.st == ST_FAULT;
    assign rsp_code     = (q.st == ST_FAULT) ? q.code : 2'd0;
    assign rsp_addr     = (q.st == ST_DONE) ? q.addr : '0;
    assign mem_rd_valid = q.st == ST_FETCH;
    assign mem_rd_addr  = cfg_base + BOOK + PA_W'({idx, 3'b000});

    // R1: idle after reset, nothing pending
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_rd_valid));

    // R2: flat lookups answer one cycle after acceptance
    assert_flat_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !seg_mode) |=> rsp_valid);

    // R4: bad configuration always yields the configuration fault
    assert_cfg_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_err) |=> (rsp_valid && rsp_fault && rsp_code == 2'd3));

    // R5: one descriptor read per lookup, never back to back
    assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> (!mem_rd_valid && !rsp_valid));

    // R10: no acceptance while a read is outstanding
    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    // R11: response is a strobe followed by idle
    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R11: faults carry no address
    assert_fault_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_addr == '0));
endmodule

// File: tb/sim_rmp_locator.sv
module sim_rmp_locator;
    localparam int PA_W = 52;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PA_W-1:0]  cfg_base = '0, cfg_last = '0;
    logic [13:0]      cfg_ctrl = '0;
    logic [9:0]       cfg_seg_cap = '0;
    logic             cfg_cap_hard = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [PA_W-1:0]  req_pa = '0;
    logic             rsp_valid, rsp_fault;
    logic [1:0]       rsp_code;
    logic [PA_W-1:0]  rsp_addr;
    logic             mem_rd_valid;
    logic [PA_W-1:0]  mem_rd_addr;
    logic             mem_rd_data_valid = 1'b0;
    logic [63:0]      mem_rd_data = '0;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    rmp_locator u0 (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_last(cfg_last),
        .cfg_ctrl(cfg_ctrl), .cfg_seg_cap(cfg_seg_cap), .cfg_cap_hard(cfg_cap_hard),
        .req_valid(req_valid), .req_ready(req_ready), .req_pa(req_pa),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
        .rsp_addr(rsp_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: outcome of one lookup given the descriptor it would see
    task automatic model(input logic [63:0] pa, input logic [63:0] desc,
                         output logic rd, output logic [63:0] rd_addr,
                         output logic flt, output logic [1:0] code, output logic [63:0] ent);
        logic [63:0] b, top, need, lim, idx, cap, off, mapped, sz;
        b = 64'(cfg_base); top = 64'(cfg_last) + 1;
        need = b + 16384 + (cfg_ctrl[0] ? 4096 : 0);
        rd = 0; rd_addr = 0; flt = 1; code = 0; ent = 0;
        if ((b % 8192) != 0 || (top % 8192) != 0 || top < need) begin
            code = 3;
        end else if (!cfg_ctrl[0]) begin
            lim = ((top - b - 16384) / 16) * 4096;
            if (pa < lim) begin
                flt = 0; ent = b + 16384 + (pa / 4096) * 16;
            end
        end else begin
            sz = 64'(cfg_ctrl[13:8]);
            idx = pa >> sz;
            cap = (cfg_cap_hard && cfg_seg_cap < 512) ? 64'(cfg_seg_cap) : 512;
            if (idx < cap) begin
                rd = 1; rd_addr = b + 16384 + idx * 8;
                mapped = 64'(desc[19:0]);
                off = pa % (64'd1 << sz);
                if (mapped == 0) code = 1;
                else if (off >= mapped * 64'h4000_0000) code = 2;
                else begin
                    flt = 0; ent = 64'(desc[51:20]) * 64'h10_0000 + (off / 4096) * 16;
                end
            end
        end
    endtask

    task automatic check_rsp(input string req, input logic flt, input logic [1:0] code, input logic [63:0] ent);
        chk(req, "rsp_valid", 64'(rsp_valid), 1);
        chk(req, "rsp_fault", 64'(rsp_fault), 64'(flt));
        chk(req, "rsp_code", 64'(rsp_code), flt ? 64'(code) : 0);
        chk(req, "rsp_addr", 64'(rsp_addr), flt ? 0 : ent);
        @(negedge clk);
        chk("R11", "strobe end", 64'(rsp_valid), 0);
        chk("R11", "ready after", 64'(req_ready), 1);
    endtask

    task automatic run(input string req, input logic [63:0] pa, input logic [63:0] desc,
                       input int lat, input logic stray);
        logic rd, flt; logic [1:0] code; logic [63:0] rda, ent;
        model(pa, desc, rd, rda, flt, code, ent);
        @(negedge clk);
        chk("R10", "ready idle", 64'(req_ready), 1);
        req_valid = 1; req_pa = PA_W'(pa);
        @(negedge clk);
        req_valid = 0;
        chk("R10", "busy", 64'(req_ready), 0);
        if (!rd) begin
            chk(req, "no read", 64'(mem_rd_valid), 0);
            check_rsp(req, flt, code, ent);
        end else begin
            chk("R5", "read strobe", 64'(mem_rd_valid), 1);
            chk("R5", "read addr", 64'(mem_rd_addr), rda);
            chk(req, "no early rsp", 64'(rsp_valid), 0);
            @(negedge clk);
            chk("R5", "single read", 64'(mem_rd_valid), 0);
            for (int i = 0; i < lat; i++) begin
                if (stray) begin req_valid = 1; req_pa = '0; end
                @(negedge clk);
                chk("R10", "stray ignored ready", 64'(req_ready), 0);
                chk("R10", "stray ignored rsp", 64'(rsp_valid), 0);
            end
            req_valid = 0;
            mem_rd_data_valid = 1; mem_rd_data = desc;
            @(negedge clk);
            mem_rd_data_valid = 0;
            check_rsp(req, flt, code, ent);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "ready", 64'(req_ready), 1);
        chk("R1", "rsp_valid", 64'(rsp_valid), 0);
        chk("R1", "mem_rd_valid", 64'(mem_rd_valid), 0);

        // flat layout: 512 records, covers 2MB
        cfg_base = 52'h10_0000; cfg_last = 52'h10_5FFF; cfg_ctrl = 14'h0000;
        run("R2", 64'h0, 0, 0, 0);
        run("R2", 64'h12345, 0, 0, 0);
        run("R2", 64'h1F_FFFF, 0, 0, 0);
        run("R3", 64'h20_0000, 0, 0, 0);
        run("R3", 64'hF_0000_0000, 0, 0, 0);

        // stray read data while idle has no effect
        @(negedge clk);
        mem_rd_data_valid = 1; mem_rd_data = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        mem_rd_data_valid = 0;
        chk("R10", "idle data rsp", 64'(rsp_valid), 0);
        chk("R10", "idle data ready", 64'(req_ready), 1);
        run("R10", 64'h3000, 0, 0, 0);

        // configuration faults
        cfg_base = 52'h10_1000; run("R4", 64'h0, 0, 0, 0);
        cfg_base = 52'h10_0000; cfg_last = 52'h10_6FFF; run("R4", 64'h0, 0, 0, 0);
        cfg_last = 52'h10_1FFF; run("R4", 64'h0, 0, 0, 0);
        cfg_last = 52'h10_3FFF; cfg_ctrl = 14'h1E01; run("R4", 64'h0, 0, 0, 0);

        // segmented, 1GB segments
        cfg_last = 52'h1F_FFFF; cfg_ctrl = 14'h1E01;
        run("R9", 64'h8000_1234, {12'h0, 32'hABC, 20'h1}, 0, 0);
        run("R7", 64'h4000_5000, {12'h0, 32'hABC, 20'h0}, 2, 1);
        run("R9", 64'h0, {12'h0, 32'h5, 20'h1}, 3, 1);
        cfg_cap_hard = 1; cfg_seg_cap = 10'd4;
        run("R6", 64'h1_0000_0000, 0, 0, 0);
        run("R6", 64'h0_C000_0000, {12'h0, 32'h7, 20'h1}, 1, 0);
        cfg_cap_hard = 0;
        run("R6", 64'h1_0000_0000, {12'h0, 32'h7, 20'h1}, 1, 0);
        run("R6", 64'h80_0000_0000, 0, 0, 0);
        run("R6", 64'h7F_C000_0000, {12'h0, 32'h9, 20'h1}, 0, 0);

        // segmented, 64GB segments
        cfg_ctrl = 14'h2401;
        run("R5", 64'hF_FFFF_FFFF, {12'h0, 32'h100, 20'h40}, 0, 0);
        run("R5", 64'h10_0000_0000, {12'h0, 32'h200, 20'h1}, 1, 0);
        run("R8", 64'h10_8000_0000, {12'h0, 32'h300, 20'h2}, 0, 0);
        run("R9", 64'h10_8000_0000, {12'h0, 32'h300, 20'h3}, 0, 0);
        run("R8", 64'h10_0000_0000 + 64'h3FFF_FFFF + 1, {12'h0, 32'h300, 20'h1}, 0, 0);
        run("R9", 64'h10_3FFF_F000, {12'h0, 32'h300, 20'h1}, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule